// File: doc/BRIEF.md
# Burst RAM Slave with AXI4 Channels

This block is a single-ported-per-direction synchronous RAM presented as an AXI4 slave with one transaction ID. The write side (AW, W, B) and the read side (AR, R) are independent state machines, so one write burst and one read burst may be in flight at once. Each side accepts a new address only when its previous burst has fully finished, so no more than one burst per direction is ever outstanding.

Addresses are byte addresses. Bursts may be INCR, FIXED or WRAP, with a transfer size up to the bus width, any byte alignment for the start address, and byte strobes on writes. WRAP is addressed exactly like INCR. A master places narrow data on the byte lanes selected by the beat address. The RAM writes only the lanes that are both strobed and inside the beat's address window, and returns read data with every lane outside that window forced to zero.

All data channels use valid/ready. A transfer happens on a rising clock edge where both are high. The slave holds RVALID, RDATA, RLAST, RRESP and BVALID steady until the master raises the matching ready. A master may hold WVALID low between beats and may deassert RREADY or BREADY for any number of cycles.

Top module: `axi_ram_slave`

## Requirements
- R1: After reset, AWREADY and ARREADY are 1 and WREADY, BVALID and RVALID are 0.
- R2: In an INCR burst (burst code 2'b01) of 1 to 256 beats, each beat's address is the previous beat's address rounded down to the transfer size (2**size bytes) plus the transfer size.
- R3: In a FIXED burst (burst code 2'b00), every beat uses the start address. A FIXED write leaves only the last beat's bytes in memory, and a FIXED read returns the same word on every beat.
- R4: A WRAP burst (burst code 2'b10) is addressed exactly like an INCR burst and never wraps around.
- R5: A write beat changes byte lane i only if WSTRB[i] is 1. Every other byte keeps its previous value.
- R6: Byte lane i of the data bus carries byte address (beat address rounded down to the bus width) + i. A sequence of half-width INCR beats fills the low half of a word first and then the high half.
- R7: The first beat of an unaligned burst covers only the lanes from the start address up to, but not including, the next size-aligned boundary. Lower lanes are neither written nor returned, and read data on lanes outside the beat window is 0.
- R8: Every read beat carries RRESP = 2'b00 (OKAY), and RLAST is 1 only on beat number ARLEN (counting from 0).
- R9: Exactly one B response with BRESP = 2'b00 follows the W beat that carries WLAST. BVALID stays high until BREADY is seen, and it is low in the cycle after the handshake.
- R10: While RVALID is high and RREADY is low, RVALID, RDATA and RLAST stay unchanged.
- R11: A read burst and a write burst to different words that run at the same time both complete with correct data.
- R12: If a read fetch and a write hit the same word in the same cycle, the read returns the data that was there before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted when high with awvalid |
| awaddr | input | ADDR_W | Write start byte address |
| awlen | input | 8 | Write beats minus one |
| awsize | input | 3 | Write transfer size, log2 bytes |
| awburst | input | 2 | Write burst type: 00 FIXED, 01 INCR, 10 WRAP |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted when high with wvalid |
| wdata | input | 8*DATA_BYTES | Write data, byte lane i at bits 8i+7:8i |
| wstrb | input | DATA_BYTES | Byte write enables |
| wlast | input | 1 | Final write beat |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response accepted |
| bresp | output | 2 | Write response, always OKAY |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted when high with arvalid |
| araddr | input | ADDR_W | Read start byte address |
| arlen | input | 8 | Read beats minus one |
| arsize | input | 3 | Read transfer size, log2 bytes |
| arburst | input | 2 | Read burst type: 00 FIXED, 01 INCR, 10 WRAP |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data accepted |
| rdata | output | 8*DATA_BYTES | Read data, lanes outside the beat window are 0 |
| rresp | output | 2 | Read response, always OKAY |
| rlast | output | 1 | Final read beat |

## Verification
The bench targets the address stepping that is easiest to get wrong. An unaligned INCR start that steps by the raw size instead of to the next boundary would put every later beat at the wrong address. A FIXED burst that advances would spread data over neighbouring words. A WRAP burst given real wrap logic would overwrite the word below the start. Byte-level cases come next: a narrow beat read from lane 0 instead of its address lane stores the wrong half. A write that ignores the start offset clobbers the low bytes of an unaligned first word, and unmasked strobes overwrite protected bytes. The read/write collision and the concurrent-burst runs expose a RAM that forwards new data or lets one channel stall the other. Held RREADY exposes read data that drifts while waiting.

// File: rtl/axi_ram_pkg.sv
package axi_ram_pkg;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10
  } burst_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_DATA,
    WR_RESP
  } wr_state_e;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_FETCH,
    RD_SEND
  } rd_state_e;

endpackage

// File: rtl/axi_ram_beat_addr.sv
// Per-beat address step and byte-lane window. Shared by both channels.
module axi_ram_beat_addr
  import axi_ram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NB     = 4
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [2:0]        size,
  input  logic [1:0]        burst,
  output logic [ADDR_W-1:0] nxt,
  output logic [NB-1:0]     lanes
);
  localparam int         LANE_W   = $clog2(NB);
  localparam logic [2:0] MAX_SIZE = 3'(LANE_W);

  logic [2:0]      eff_size;
  logic [ADDR_W:0] step;
  logic [ADDR_W:0] aligned;
  logic [ADDR_W:0] span_end;

  always_comb begin
    eff_size = (size > MAX_SIZE) ? MAX_SIZE : size;
    step     = (ADDR_W + 1)'(1) << eff_size;
    aligned  = {1'b0, cur} & ~(step - (ADDR_W + 1)'(1));
    span_end = aligned + step;
    // FIXED holds the address; INCR and WRAP both step to the next boundary.
    nxt      = (burst == BURST_FIXED) ? cur : span_end[ADDR_W-1:0];
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [ADDR_W:0] lane_addr;
    assign lane_addr = {1'b0, cur[ADDR_W-1:LANE_W], LANE_W'(i)};
    assign lanes[i]  = (lane_addr >= {1'b0, cur}) && (lane_addr < span_end);
  end

endmodule

// File: rtl/axi_ram_store.sv
// Word-organised RAM with per-byte write enables and a registered read port.
module axi_ram_store #(
  parameter int NB    = 4,
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [NB-1:0]            wbe,
  input  logic [8*NB-1:0]          wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [8*NB-1:0]          rdata
);
  logic [8*NB-1:0] mem [DEPTH];

  // Read samples the array before this edge's write lands: old data wins.
  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (we && wbe[b]) mem[waddr][8*b +: 8] <= wdata[8*b +: 8];
    end
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/axi_ram_wr_ctrl.sv
module axi_ram_wr_ctrl
  import axi_ram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NB     = 4,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [7:0]        awlen,
  input  logic [2:0]        awsize,
  input  logic [1:0]        awburst,
  input  logic              wvalid,
  output logic              wready,
  input  logic [8*NB-1:0]   wdata,
  input  logic [NB-1:0]     wstrb,
  input  logic              wlast,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_waddr,
  output logic [NB-1:0]     mem_wbe,
  output logic [8*NB-1:0]   mem_wdata
);
  localparam int LANE_W = $clog2(NB);

  wr_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic [7:0]        len_q;
  logic [7:0]        cnt_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;
  logic [NB-1:0]     lanes;
  logic              w_fire;
  logic              beat_end;

  axi_ram_beat_addr #(.ADDR_W(ADDR_W), .NB(NB)) u_step (
    .cur   (addr_q),
    .size  (size_q),
    .burst (burst_q),
    .nxt   (addr_nxt),
    .lanes (lanes)
  );

  assign awready   = (state_q == WR_IDLE);
  assign wready    = (state_q == WR_DATA);
  assign bvalid    = (state_q == WR_RESP);
  assign bresp     = RESP_OKAY;
  assign w_fire    = wvalid && wready;
  assign beat_end  = wlast || (cnt_q == len_q);
  assign mem_we    = w_fire;
  assign mem_wbe   = wstrb & lanes;
  assign mem_waddr = addr_q[LANE_W +: IDX_W];
  assign mem_wdata = wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      size_q  <= '0;
      burst_q <= '0;
    end else begin
      unique case (state_q)
        WR_IDLE: if (awvalid) begin
          addr_q  <= awaddr;
          len_q   <= awlen;
          size_q  <= awsize;
          burst_q <= awburst;
          cnt_q   <= '0;
          state_q <= WR_DATA;
        end
        WR_DATA: if (w_fire) begin
          addr_q <= addr_nxt;
          cnt_q  <= cnt_q + 8'd1;
          if (beat_end) state_q <= WR_RESP;
        end
        WR_RESP: if (bready) state_q <= WR_IDLE;
        default: state_q <= WR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/axi_ram_rd_ctrl.sv
module axi_ram_rd_ctrl
  import axi_ram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NB     = 4,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [7:0]        arlen,
  input  logic [2:0]        arsize,
  input  logic [1:0]        arburst,
  output logic              rvalid,
  input  logic              rready,
  output logic [8*NB-1:0]   rdata,
  output logic [1:0]        rresp,
  output logic              rlast,
  output logic              mem_re,
  output logic [IDX_W-1:0]  mem_raddr,
  input  logic [8*NB-1:0]   mem_rdata
);
  localparam int LANE_W = $clog2(NB);

  rd_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic [7:0]        len_q;
  logic [7:0]        cnt_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;
  logic [NB-1:0]     lanes;
  logic              final_beat;

  axi_ram_beat_addr #(.ADDR_W(ADDR_W), .NB(NB)) u_step (
    .cur   (addr_q),
    .size  (size_q),
    .burst (burst_q),
    .nxt   (addr_nxt),
    .lanes (lanes)
  );

  assign final_beat = (cnt_q == len_q);
  assign arready    = (state_q == RD_IDLE);
  assign rvalid     = (state_q == RD_SEND);
  assign rlast      = rvalid && final_beat;
  assign rresp      = RESP_OKAY;
  assign mem_re     = (state_q == RD_FETCH);
  assign mem_raddr  = addr_q[LANE_W +: IDX_W];

  // Lanes outside the beat window read as zero.
  for (genvar i = 0; i < NB; i++) begin : g_mask
    assign rdata[8*i +: 8] = lanes[i] ? mem_rdata[8*i +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      size_q  <= '0;
      burst_q <= '0;
    end else begin
      unique case (state_q)
        RD_IDLE: if (arvalid) begin
          addr_q  <= araddr;
          len_q   <= arlen;
          size_q  <= arsize;
          burst_q <= arburst;
          cnt_q   <= '0;
          state_q <= RD_FETCH;
        end
        RD_FETCH: state_q <= RD_SEND;
        RD_SEND: if (rready) begin
          if (final_beat) begin
            state_q <= RD_IDLE;
          end else begin
            addr_q  <= addr_nxt;
            cnt_q   <= cnt_q + 8'd1;
            state_q <= RD_FETCH;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/axi_ram_slave.sv
module axi_ram_slave #(
  parameter int DATA_BYTES = 4,
  parameter int DEPTH      = 1024,
  parameter int ADDR_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    awvalid,
  output logic                    awready,
  input  logic [ADDR_W-1:0]       awaddr,
  input  logic [7:0]              awlen,
  input  logic [2:0]              awsize,
  input  logic [1:0]              awburst,
  input  logic                    wvalid,
  output logic                    wready,
  input  logic [8*DATA_BYTES-1:0] wdata,
  input  logic [DATA_BYTES-1:0]   wstrb,
  input  logic                    wlast,
  output logic                    bvalid,
  input  logic                    bready,
  output logic [1:0]              bresp,
  input  logic                    arvalid,
  output logic                    arready,
  input  logic [ADDR_W-1:0]       araddr,
  input  logic [7:0]              arlen,
  input  logic [2:0]              arsize,
  input  logic [1:0]              arburst,
  output logic                    rvalid,
  input  logic                    rready,
  output logic [8*DATA_BYTES-1:0] rdata,
  output logic [1:0]              rresp,
  output logic                    rlast
);
  localparam int DATA_W = 8 * DATA_BYTES;
  localparam int IDX_W  = $clog2(DEPTH);

  logic              mem_we;
  logic [IDX_W-1:0]  mem_waddr;
  logic [DATA_BYTES-1:0] mem_wbe;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_re;
  logic [IDX_W-1:0]  mem_raddr;
  logic [DATA_W-1:0] mem_rdata;

  axi_ram_wr_ctrl #(.ADDR_W(ADDR_W), .NB(DATA_BYTES), .IDX_W(IDX_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .awvalid   (awvalid),
    .awready   (awready),
    .awaddr    (awaddr),
    .awlen     (awlen),
    .awsize    (awsize),
    .awburst   (awburst),
    .wvalid    (wvalid),
    .wready    (wready),
    .wdata     (wdata),
    .wstrb     (wstrb),
    .wlast     (wlast),
    .bvalid    (bvalid),
    .bready    (bready),
    .bresp     (bresp),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wbe   (mem_wbe),
    .mem_wdata (mem_wdata)
  );

  axi_ram_rd_ctrl #(.ADDR_W(ADDR_W), .NB(DATA_BYTES), .IDX_W(IDX_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .arvalid   (arvalid),
    .arready   (arready),
    .araddr    (araddr),
    .arlen     (arlen),
    .arsize    (arsize),
    .arburst   (arburst),
    .rvalid    (rvalid),
    .rready    (rready),
    .rdata     (rdata),
    .rresp     (rresp),
    .rlast     (rlast),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr),
    .mem_rdata (mem_rdata)
  );

  axi_ram_store #(.NB(DATA_BYTES), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wbe   (mem_wbe),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

endmodule

// File: rtl/axi_ram_slave_chk.sv
module axi_ram_slave_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arvalid,
  input logic          arready,
  input logic [7:0]    arlen,
  input logic          rvalid,
  input logic          rready,
  input logic [8*NB-1:0] rdata,
  input logic [1:0]    rresp,
  input logic          rlast,
  input logic          wvalid,
  input logic          wready,
  input logic          wlast,
  input logic          bvalid,
  input logic          bready,
  input logic [1:0]    bresp
);
  logic [7:0] beat_cnt;
  logic [7:0] beat_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      beat_len <= '0;
    end else if (arvalid && arready) begin
      beat_cnt <= '0;
      beat_len <= arlen;
    end else if (rvalid && rready) begin
      beat_cnt <= beat_cnt + 8'd1;
    end
  end

  a_r8_rresp_okay: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> rresp == 2'b00);

  a_r8_rlast_final: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> rlast == (beat_cnt == beat_len));

  a_r9_bresp_okay: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> bresp == 2'b00);

  a_r9_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);

  a_r9_b_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid) |-> $past(wvalid && wready && wlast));

  a_r10_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rlast));

endmodule

bind axi_ram_slave axi_ram_slave_chk #(.NB(DATA_BYTES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .arvalid (arvalid),
  .arready (arready),
  .arlen   (arlen),
  .rvalid  (rvalid),
  .rready  (rready),
  .rdata   (rdata),
  .rresp   (rresp),
  .rlast   (rlast),
  .wvalid  (wvalid),
  .wready  (wready),
  .wlast   (wlast),
  .bvalid  (bvalid),
  .bready  (bready),
  .bresp   (bresp)
);

// File: tb/axi_ram_slave_test.sv
`timescale 1ns/1ps
module axi_ram_slave_test;
  localparam int NB     = 4;
  localparam int DEPTH  = 1024;
  localparam int ADDR_W = 16;
  localparam int DW     = 8 * NB;
  localparam int MEMB   = NB * DEPTH;

  logic clk = 1'b0;
  logic rst_n;
  logic awvalid, awready, wvalid, wready, wlast, bvalid, bready;
  logic arvalid, arready, rvalid, rready, rlast;
  logic [ADDR_W-1:0] awaddr, araddr;
  logic [7:0] awlen, arlen;
  logic [2:0] awsize, arsize;
  logic [1:0] awburst, arburst, bresp, rresp;
  logic [DW-1:0] wdata, rdata;
  logic [NB-1:0] wstrb;

  always #4 clk = ~clk;

  axi_ram_slave #(.DATA_BYTES(NB), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) uut (.*);

  logic [7:0]    model [MEMB];
  logic [DW-1:0] wbuf [256];
  logic [NB-1:0] sbuf [256];
  logic [DW-1:0] rbuf [256];
  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  function automatic logic [NB-1:0] exp_lanes(input int unsigned a, input int unsigned sz);
    int unsigned bytes = 1 << sz;
    int unsigned hi = (a / bytes) * bytes + bytes;
    logic [NB-1:0] r;
    for (int i = 0; i < NB; i++) begin
      int unsigned la = (a / NB) * NB + i;
      r[i] = (la >= a) && (la < hi);
    end
    return r;
  endfunction

  function automatic int unsigned exp_next(input int unsigned a, input int unsigned sz, input int bt);
    int unsigned bytes = 1 << sz;
    if (bt == 0) return a;
    return (a / bytes) * bytes + bytes;
  endfunction

  function automatic logic [DW-1:0] model_word(input int unsigned a, input logic [NB-1:0] ln);
    logic [DW-1:0] w = '0;
    for (int i = 0; i < NB; i++)
      if (ln[i]) w[8*i +: 8] = model[((a / NB) * NB + i) % MEMB];
    return w;
  endfunction

  task automatic axi_write(input int unsigned a, input int len, input int sz, input int bt, input bit gaps);
    int unsigned cur = a;
    logic [NB-1:0] ln;
    @(negedge clk);
    awaddr = ADDR_W'(a); awlen = 8'(len); awsize = 3'(sz); awburst = 2'(bt); awvalid = 1'b1;
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 1'b0;
    for (int k = 0; k <= len; k++) begin
      if (gaps) repeat ($urandom % 2) @(negedge clk);
      wvalid = 1'b1; wdata = wbuf[k]; wstrb = sbuf[k]; wlast = (k == len);
      while (!wready) @(negedge clk);
      ln = exp_lanes(cur, sz);
      for (int i = 0; i < NB; i++)
        if (ln[i] && sbuf[k][i]) model[((cur / NB) * NB + i) % MEMB] = wbuf[k][8*i +: 8];
      cur = exp_next(cur, sz, bt);
      @(negedge clk);
      wvalid = 1'b0; wlast = 1'b0;
    end
    forever begin
      bready = ($urandom % 3) != 0;
      if (bvalid && bready) break;
      @(negedge clk);
    end
    check(bresp == 2'b00, "R9 bresp okay", bresp, 0);
    @(negedge clk);
    bready = 1'b0;
    check(!bvalid, "R9 single response", bvalid, 0);
  endtask

  task automatic axi_read(input int unsigned a, input int len, input int sz, input int bt, input string tag);
    int unsigned cur = a;
    int k = 0;
    logic [DW-1:0] expw;
    @(negedge clk);
    araddr = ADDR_W'(a); arlen = 8'(len); arsize = 3'(sz); arburst = 2'(bt); arvalid = 1'b1;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    while (k <= len) begin
      rready = ($urandom % 4) != 0;
      if (rvalid && rready) begin
        expw = model_word(cur, exp_lanes(cur, sz));
        check(rdata === expw, tag, rdata, expw);
        check(rresp == 2'b00 && rlast == (k == len), "R8 rresp/rlast", {rresp, rlast}, {2'b00, k == len});
        rbuf[k] = rdata;
        cur = exp_next(cur, sz, bt);
        k++;
      end
      @(negedge clk);
    end
    rready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] hold, old;
    logic [15:0] v [4];
    process::self().srandom(32'h5eed_0042);
    $urandom(1234);
    rst_n = 1'b0;
    awvalid = 0; wvalid = 0; wlast = 0; bready = 0; arvalid = 0; rready = 0;
    awaddr = 0; awlen = 0; awsize = 0; awburst = 0; wdata = 0; wstrb = 0;
    araddr = 0; arlen = 0; arsize = 0; arburst = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(awready && arready && !wready && !bvalid && !rvalid, "R1 reset outputs",
          {awready, arready, wready, bvalid, rvalid}, 5'b11000);

    // Fill memory so the model matches from the start.
    for (int blk = 0; blk < 4; blk++) begin
      for (int k = 0; k < 256; k++) begin wbuf[k] = $urandom; sbuf[k] = '1; end
      axi_write(blk * 1024, 255, 2, 1, 0);
    end
    axi_read(0, 255, 2, 1, "R2 full-block readback");

    // R2 INCR stepping
    for (int k = 0; k < 8; k++) begin wbuf[k] = $urandom; sbuf[k] = '1; end
    axi_write(32'h40, 7, 2, 1, 1);
    axi_read(32'h40, 7, 2, 1, "R2 incr readback");

    // R3 FIXED write keeps last beat, FIXED read repeats
    for (int k = 0; k < 4; k++) begin wbuf[k] = 32'hA0A0_0000 + k; sbuf[k] = '1; end
    axi_write(32'h80, 3, 2, 0, 1);
    axi_read(32'h80, 3, 2, 0, "R3 fixed read");
    for (int k = 0; k < 4; k++) check(rbuf[k] == 32'hA0A0_0003, "R3 fixed last beat", rbuf[k], 32'hA0A0_0003);

    // R4 WRAP addressed as INCR: beat 3 lands at 0x214, not 0x200
    for (int k = 0; k < 4; k++) begin wbuf[k] = 32'hC0DE_0000 + k; sbuf[k] = '1; end
    old = model_word(32'h200, '1);
    axi_write(32'h208, 3, 2, 2, 0);
    axi_read(32'h214, 0, 2, 1, "R4 wrap beat 3");
    check(rbuf[0] == 32'hC0DE_0003, "R4 wrap no wrap-around", rbuf[0], 32'hC0DE_0003);
    axi_read(32'h200, 0, 2, 1, "R4 word below untouched");
    check(rbuf[0] == old, "R4 word below untouched", rbuf[0], old);

    // R5 strobes
    wbuf[0] = 32'h1122_3344; sbuf[0] = '1;
    axi_write(32'h300, 0, 2, 1, 0);
    wbuf[0] = 32'hAABB_CCDD; sbuf[0] = 4'b0101;
    axi_write(32'h300, 0, 2, 1, 0);
    axi_read(32'h300, 0, 2, 1, "R5 strobe merge");
    check(rbuf[0] == 32'h11BB_33DD, "R5 strobe merge", rbuf[0], 32'h11BB_33DD);

    // R6 half-width beats, junk on the inactive half
    for (int k = 0; k < 4; k++) begin
      v[k] = 16'($urandom);
      wbuf[k] = (k % 2) ? {v[k], 16'hDEAD} : {16'hBEEF, v[k]};
      sbuf[k] = '1;
    end
    axi_write(32'h400, 3, 1, 1, 1);
    axi_read(32'h400, 1, 2, 1, "R6 narrow halves");
    check(rbuf[0] == {v[1], v[0]}, "R6 low half first", rbuf[0], {v[1], v[0]});
    check(rbuf[1] == {v[3], v[2]}, "R6 second word", rbuf[1], {v[3], v[2]});
    // R6 byte beats
    for (int k = 0; k < 4; k++) begin wbuf[k] = {4{8'(8'h10 + k)}}; sbuf[k] = '1; end
    axi_write(32'h410, 3, 0, 1, 0);
    axi_read(32'h410, 0, 2, 1, "R6 byte beats");
    check(rbuf[0] == 32'h1312_1110, "R6 byte lanes", rbuf[0], 32'h1312_1110);

    // R7 unaligned first beat
    wbuf[0] = 32'hCAFE_F00D; wbuf[1] = 32'hCAFE_F00D; sbuf[0] = '1; sbuf[1] = '1;
    axi_write(32'h500, 1, 2, 1, 0);
    wbuf[0] = 32'h1122_3344; wbuf[1] = 32'h5566_7788;
    axi_write(32'h501, 1, 2, 1, 0);
    axi_read(32'h500, 1, 2, 1, "R7 aligned readback");
    check(rbuf[0] == 32'h1122_330D, "R7 low byte kept", rbuf[0], 32'h1122_330D);
    check(rbuf[1] == 32'h5566_7788, "R7 second beat aligned", rbuf[1], 32'h5566_7788);
    axi_read(32'h501, 0, 2, 1, "R7 unaligned read");
    check(rbuf[0] == 32'h1122_3300, "R7 lane below start zero", rbuf[0], 32'h1122_3300);

    // R10 back-pressure hold
    @(negedge clk);
    araddr = 16'h300; arlen = 0; arsize = 2; arburst = 1; arvalid = 1; rready = 0;
    while (!arready) @(negedge clk);
    @(negedge clk) arvalid = 0;
    while (!rvalid) @(negedge clk);
    hold = rdata;
    repeat (4) @(negedge clk);
    check(rvalid && rdata == hold && rlast, "R10 held under back-pressure", rdata, hold);
    check(hold == 32'h11BB_33DD, "R10 held data value", hold, 32'h11BB_33DD);
    rready = 1;
    @(negedge clk) rready = 0;
    check(!rvalid, "R10 released after handshake", rvalid, 0);

    // R11 concurrent read and write
    for (int k = 0; k < 16; k++) begin wbuf[k] = $urandom; sbuf[k] = '1; end
    fork
      axi_write(32'h800, 15, 2, 1, 1);
      axi_read(32'hC00, 15, 2, 1, "R11 concurrent read");
    join
    axi_read(32'h800, 15, 2, 1, "R11 concurrent write result");

    // R12 same-cycle collision returns old data
    old = model_word(32'h600, '1);
    @(negedge clk);
    check(awready && arready, "R12 both idle", {awready, arready}, 2'b11);
    awaddr = 16'h600; awlen = 0; awsize = 2; awburst = 1; awvalid = 1;
    araddr = 16'h600; arlen = 0; arsize = 2; arburst = 1; arvalid = 1;
    wvalid = 1; wdata = 32'h0BAD_BEEF; wstrb = '1; wlast = 1; rready = 0; bready = 0;
    @(negedge clk);
    awvalid = 0; arvalid = 0;
    @(negedge clk);
    wvalid = 0; wlast = 0;
    check(rvalid && rdata == old, "R12 read sees old word", rdata, old);
    rready = 1; bready = 1;
    @(negedge clk);
    rready = 0; bready = 0;
    for (int i = 0; i < NB; i++) model[32'h600 + i] = 8'(32'h0BAD_BEEF >> (8 * i));
    axi_read(32'h600, 0, 2, 1, "R12 new word after collision");

    // Random mix of burst types, sizes, alignments and strobes (R2 R3 R4 R5 R7)
    for (int it = 0; it < 30; it++) begin
      int bt = $urandom % 3;
      int sz = $urandom % 3;
      int len = (bt == 0) ? ($urandom % 16) : ($urandom % 32);
      int unsigned a = $urandom % 2048;
      for (int k = 0; k <= len; k++) begin wbuf[k] = $urandom; sbuf[k] = NB'($urandom); end
      axi_write(a, len, sz, bt, 1);
      axi_read(a, len, sz, $urandom % 3 == 0 ? 0 : bt, "R2 random burst readback");
      axi_read(a & ~32'h3, len, 2, 1, "R5 random word readback");
    end

    finish_run();
  end

endmodule